// File: doc/BRIEF.md
# DSP Program Sequencer with Hardware Loop

This block drives the program counter of a small DSP. It presents an address to a synchronous program RAM every cycle and receives that word on the next cycle. So while one instruction is decoded, the following address is already being fetched. The sequencer decodes only control instructions:

- unconditional jump
- conditional jump on a selected status flag
- loop-bottom
- loads of the loop-top and loop-count registers
- end

Every other word passes through as a no-op, to be handled by the arithmetic datapath elsewhere.

A host starts a run by pulsing `start_i` with a start address while the sequencer is idle. The run continues until an end instruction clears the execute flag. A transfer-busy flag from the DMA engine is received as condition flag 0. It never stalls or stops the sequencer, and the DMA engine keeps running after a halt.

Instruction word fields (32-bit default):

| Field | Bits | Meaning |
|---|---|---|
| Opcode | [31:28] | 1 jump, 2 conditional jump, 3 loop-bottom, 4 load loop-top, 5 load loop-count, 6 end; any other value is a no-op |
| Flag polarity | [20] | Used by the conditional jump |
| Flag select | [17:16] | Used by the conditional jump |
| Immediate | [7:0] | Target address or loaded value |

Top module: `dsp_seq`

## Requirements
- R1: While `rst_ni` is low, `exec_o` is 0 and `pram_addr_o` is 0. The loop-top and loop-count registers are cleared.
- R2: When `exec_o` is 0 and `start_i` is 1 at a rising edge, `exec_o` becomes 1 and `pram_addr_o` takes `start_addr_i` after that edge. A `start_i` that arrives while `exec_o` is 1 is ignored.
- R3: While running, the word at address A is returned on `pram_rdata_i` in the cycle after `pram_addr_o` = A, and it is decoded in that cycle. In every cycle that does not redirect or halt, `pram_addr_o` increments by one (modulo 256).
- R4: A jump (opcode 1) loads its immediate [7:0] into the address register. The word fetched just after the jump still executes, which gives one delay slot.
- R5: A conditional jump (opcode 2) tests the flag vector {`flags_i`[2:0], `dma_busy_i`}. Bits [17:16] select the flag, with index 0 being `dma_busy_i`. The jump is taken when the selected flag equals bit 20. Otherwise the sequencer falls through. A taken jump has the same delay slot as R4.
- R6: Opcode 4 loads immediate [7:0] into the loop-top register. Opcode 5 loads immediate [7:0] into the loop counter.
- R7: At a loop-bottom (opcode 3) with a nonzero counter, the counter decrements and the address reloads from the loop-top register, with one delay slot. With a zero counter, execution falls through. A counter preloaded with N therefore runs the body N+1 times.
- R8: At an end (opcode 6), `exec_o` clears and `pram_addr_o` stays at the address following the end instruction. The already-prefetched word is not executed. While idle, `pram_addr_o` is held.
- R9: `dma_busy_i` has no effect other than as flag 0. An end halts the sequencer while `dma_busy_i` is 1.
- R10: Opcodes 0 and 7 to 15 change nothing beyond the normal increment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Host request to start a run |
| start_addr_i | input | 8 | First program address of the run |
| pram_addr_o | output | 8 | Program RAM read address |
| pram_rdata_i | input | 32 | Program RAM word, one cycle after its address |
| dma_busy_i | input | 1 | DMA transfer in progress (condition flag 0) |
| flags_i | input | 3 | Condition flags 1 to 3 |
| exec_o | output | 1 | Execute flag, high while the program runs |

## Verification
The hardest situation to reach is a control instruction that lands in the delay slot of another control instruction. Examples are a loop-bottom right after a taken jump, or an end sitting in the slot of a loop-bottom. In those cases two redirects or a redirect and a halt follow back to back. To get there, the bench fills the program RAM with random words that are dense in control opcodes and random targets. It also toggles the flags and restarts at random, and compares the address and execute flag every cycle against a reference model written from the requirements. Directed programs add a counted loop and an end while DMA is busy.

// File: rtl/dsp_seq_pkg.sv
package dsp_seq_pkg;

  typedef enum logic [3:0] {
    OP_NOP   = 4'd0,
    OP_JMP   = 4'd1,
    OP_JMPC  = 4'd2,
    OP_BTM   = 4'd3,
    OP_LDTOP = 4'd4,
    OP_LDCNT = 4'd5,
    OP_END   = 4'd6
  } op_e;

  typedef struct packed {
    logic jmp;
    logic jmpc;
    logic btm;
    logic ld_top;
    logic ld_cnt;
    logic stop;
  } dec_t;

  localparam int unsigned OP_W = 4;

endpackage

// File: rtl/dsp_seq_decode.sv
module dsp_seq_decode
  import dsp_seq_pkg::*;
#(
  parameter int unsigned IW = 32
) (
  input  logic          vld_i,
  input  logic [IW-1:0] instr_i,
  output dec_t          dec_o
);

  localparam int unsigned OP_LSB = IW - OP_W;

  logic [OP_W-1:0] op;
  assign op = instr_i[OP_LSB +: OP_W];

  always_comb begin
    dec_o = '0;
    if (vld_i) begin
      case (op)
        OP_JMP:   dec_o.jmp    = 1'b1;
        OP_JMPC:  dec_o.jmpc   = 1'b1;
        OP_BTM:   dec_o.btm    = 1'b1;
        OP_LDTOP: dec_o.ld_top = 1'b1;
        OP_LDCNT: dec_o.ld_cnt = 1'b1;
        OP_END:   dec_o.stop   = 1'b1;
        default:  dec_o        = '0;
      endcase
    end
  end

endmodule

// File: rtl/dsp_seq_cond.sv
module dsp_seq_cond #(
  parameter int unsigned FLAG_N = 4,
  localparam int unsigned SEL_W = (FLAG_N > 1) ? $clog2(FLAG_N) : 1
) (
  input  logic [FLAG_N-1:0] flags_i,
  input  logic [SEL_W-1:0]  sel_i,
  input  logic              pol_i,
  output logic              hit_o
);

  logic flag;

  always_comb begin
    flag = 1'b0;
    for (int i = 0; i < FLAG_N; i++) begin
      if (sel_i == SEL_W'(i)) flag = flags_i[i];
    end
  end

  assign hit_o = (flag == pol_i);

endmodule

// File: rtl/dsp_seq_loop.sv
module dsp_seq_loop #(
  parameter int unsigned AW = 8,
  parameter int unsigned CW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ld_top_i,
  input  logic          ld_cnt_i,
  input  logic          btm_i,
  input  logic [AW-1:0] imm_top_i,
  input  logic [CW-1:0] imm_cnt_i,
  output logic [AW-1:0] top_o,
  output logic [CW-1:0] cnt_o,
  output logic          take_o
);

  logic [AW-1:0] top_q;
  logic [CW-1:0] cnt_q;

  assign take_o = btm_i && (cnt_q != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      top_q <= '0;
    end else if (ld_top_i) begin
      top_q <= imm_top_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (ld_cnt_i) begin
      cnt_q <= imm_cnt_i;
    end else if (take_o) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign top_o = top_q;
  assign cnt_o = cnt_q;

endmodule

// File: rtl/dsp_seq_pc.sv
module dsp_seq_pc #(
  parameter int unsigned AW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [AW-1:0] start_addr_i,
  input  logic          load_i,
  input  logic [AW-1:0] load_addr_i,
  input  logic          halt_i,
  output logic [AW-1:0] pc_o,
  output logic          exec_o,
  output logic          vld_o
);

  logic [AW-1:0] pc_q;
  logic          exec_q;
  logic          vld_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q   <= '0;
      exec_q <= 1'b0;
      vld_q  <= 1'b0;
    end else if (!exec_q) begin
      vld_q <= 1'b0;
      if (start_i) begin
        exec_q <= 1'b1;
        pc_q   <= start_addr_i;
      end
    end else begin
      // word arriving next cycle is live unless this cycle halts
      vld_q <= !halt_i;
      if (halt_i) begin
        exec_q <= 1'b0;
      end else if (load_i) begin
        pc_q <= load_addr_i;
      end else begin
        pc_q <= pc_q + 1'b1;
      end
    end
  end

  assign pc_o   = pc_q;
  assign exec_o = exec_q;
  assign vld_o  = vld_q;

endmodule

// File: rtl/dsp_seq.sv
module dsp_seq
  import dsp_seq_pkg::*;
#(
  parameter int unsigned AW     = 8,
  parameter int unsigned CW     = 8,
  parameter int unsigned IW     = 32,
  parameter int unsigned FLAG_N = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [AW-1:0]     start_addr_i,
  output logic [AW-1:0]     pram_addr_o,
  input  logic [IW-1:0]     pram_rdata_i,
  input  logic              dma_busy_i,
  input  logic [FLAG_N-2:0] flags_i,
  output logic              exec_o
);

  localparam int unsigned SEL_W   = (FLAG_N > 1) ? $clog2(FLAG_N) : 1;
  localparam int unsigned SEL_LSB = 16;
  localparam int unsigned POL_BIT = 20;

  dec_t          dec;
  logic          vld;
  logic          hit;
  logic          btm_take;
  logic          pc_load;
  logic          halt;
  logic [AW-1:0] load_addr;
  logic [AW-1:0] top;
  logic [CW-1:0] cnt;
  logic [AW-1:0] imm_a;
  logic [CW-1:0] imm_c;
  logic [FLAG_N-1:0] cond_vec;
  logic          unused_bits;

  assign imm_a       = pram_rdata_i[AW-1:0];
  assign imm_c       = pram_rdata_i[CW-1:0];
  assign cond_vec    = {flags_i, dma_busy_i};
  assign unused_bits = ^pram_rdata_i;

  dsp_seq_decode #(.IW(IW)) u_dec (
    .vld_i   (vld),
    .instr_i (pram_rdata_i),
    .dec_o   (dec)
  );

  dsp_seq_cond #(.FLAG_N(FLAG_N)) u_cond (
    .flags_i (cond_vec),
    .sel_i   (pram_rdata_i[SEL_LSB +: SEL_W]),
    .pol_i   (pram_rdata_i[POL_BIT]),
    .hit_o   (hit)
  );

  dsp_seq_loop #(.AW(AW), .CW(CW)) u_loop (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ld_top_i  (dec.ld_top),
    .ld_cnt_i  (dec.ld_cnt),
    .btm_i     (dec.btm),
    .imm_top_i (imm_a),
    .imm_cnt_i (imm_c),
    .top_o     (top),
    .cnt_o     (cnt),
    .take_o    (btm_take)
  );

  assign pc_load   = dec.jmp || (dec.jmpc && hit) || btm_take;
  assign load_addr = btm_take ? top : imm_a;
  assign halt      = dec.stop;

  dsp_seq_pc #(.AW(AW)) u_pc (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_i      (start_i),
    .start_addr_i (start_addr_i),
    .load_i       (pc_load),
    .load_addr_i  (load_addr),
    .halt_i       (halt),
    .pc_o         (pram_addr_o),
    .exec_o       (exec_o),
    .vld_o        (vld)
  );

endmodule

// File: rtl/dsp_seq_chk.sv
module dsp_seq_chk #(
  parameter int unsigned AW = 8,
  parameter int unsigned CW = 8
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          start_i,
  input logic [AW-1:0] start_addr_i,
  input logic          exec_o,
  input logic [AW-1:0] pram_addr_o,
  input logic          pc_load,
  input logic [AW-1:0] load_addr,
  input logic          halt,
  input logic          btm_take,
  input logic [CW-1:0] cnt
);

  // R2
  start_run_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!exec_o && start_i) |=> (exec_o && pram_addr_o == $past(start_addr_i)));

  // R3
  step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exec_o && !pc_load && !halt) |=> (pram_addr_o == AW'($past(pram_addr_o) + 1'b1)));

  // R4
  redirect_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exec_o && pc_load && !halt) |=> (pram_addr_o == $past(load_addr)));

  // R7
  loop_dec_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    btm_take |=> (cnt == CW'($past(cnt) - 1'b1)));

  // R8
  end_stop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exec_o && halt) |=> (!exec_o && $stable(pram_addr_o)));

  // R8
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!exec_o && !start_i) |=> (!exec_o && $stable(pram_addr_o)));

endmodule

bind dsp_seq dsp_seq_chk #(.AW(AW), .CW(CW)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .start_i      (start_i),
  .start_addr_i (start_addr_i),
  .exec_o       (exec_o),
  .pram_addr_o  (pram_addr_o),
  .pc_load      (pc_load),
  .load_addr    (load_addr),
  .halt         (halt),
  .btm_take     (btm_take),
  .cnt          (cnt)
);

// File: tb/sim_dsp_seq.sv
`timescale 1ns/1ps
module sim_dsp_seq;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [7:0]  start_addr = '0;
  logic [7:0]  addr;
  logic [31:0] rdata = '0;
  logic        dma_busy = 1'b0;
  logic [2:0]  flags = '0;
  logic        exec;

  logic [31:0] mem [256];

  int vectors = 0;
  int errors  = 0;
  int cycles  = 0;
  bit done    = 1'b0;

  // reference model state
  logic [7:0]  m_pc, m_top, m_cnt;
  logic        m_exec, m_vld;
  logic [31:0] m_rd;
  string       m_tag;

  always #2.5 clk = ~clk;

  dsp_seq u0 (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .start_i      (start),
    .start_addr_i (start_addr),
    .pram_addr_o  (addr),
    .pram_rdata_i (rdata),
    .dma_busy_i   (dma_busy),
    .flags_i      (flags),
    .exec_o       (exec)
  );

  always @(posedge clk) rdata <= mem[addr];

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000 && !done) begin
      errors = errors + 1;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  function automatic logic [31:0] mk(input logic [3:0] op, input logic pol,
                                     input logic [1:0] sel, input logic [7:0] imm);
    return {op, 7'd0, pol, 2'd0, sel, 8'd0, imm};
  endfunction

  task automatic model_reset();
    m_pc = '0; m_top = '0; m_cnt = '0; m_exec = 1'b0; m_vld = 1'b0; m_rd = '0;
    m_tag = "R1";
  endtask

  // one clock of the architectural rules, using the inputs held at this edge
  task automatic model_step();
    logic [31:0] w;
    logic [3:0]  op;
    logic [3:0]  fv;
    logic [7:0]  npc, ntop, ncnt;
    logic        nexec, hit;
    w     = m_vld ? m_rd : 32'd0;
    op    = w[31:28];
    fv    = {flags, dma_busy};
    hit   = (fv[w[17:16]] == w[20]);
    npc   = m_exec ? m_pc + 8'd1 : m_pc;
    nexec = m_exec; ntop = m_top; ncnt = m_cnt;
    m_tag = m_exec ? "R3/R10" : "R8 idle";
    case (op)
      4'd1: begin npc = w[7:0]; m_tag = "R4"; end
      4'd2: begin if (hit) npc = w[7:0]; m_tag = "R5/R9"; end
      4'd3: begin
        if (m_cnt != 8'd0) begin ncnt = m_cnt - 8'd1; npc = m_top; end
        m_tag = "R7";
      end
      4'd4: begin ntop = w[7:0]; m_tag = "R6"; end
      4'd5: begin ncnt = w[7:0]; m_tag = "R6"; end
      4'd6: begin nexec = 1'b0; npc = m_pc; m_tag = "R8"; end
      default: ;
    endcase
    if (!m_exec && start) begin nexec = 1'b1; npc = start_addr; m_tag = "R2"; end
    m_vld  = m_exec && (op != 4'd6);
    m_rd   = mem[m_pc];
    m_pc   = npc; m_exec = nexec; m_top = ntop; m_cnt = ncnt;
  endtask

  task automatic check(input string tag, input logic [7:0] a_exp, input logic e_exp);
    vectors = vectors + 1;
    if (addr !== a_exp || exec !== e_exp) begin
      errors = errors + 1;
      $display("FAIL %s: addr=%0h exec=%0b expected addr=%0h exec=%0b",
               tag, addr, exec, a_exp, e_exp);
    end
  endtask

  // advance one clock, compare at the falling edge
  task automatic tick();
    @(negedge clk);
    model_step();
    check(m_tag, m_pc, m_exec);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    start = 1'b0;
    model_reset();
    #1;
    check("R1", 8'd0, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic clear_mem();
    for (int i = 0; i < 256; i++) mem[i] = 32'd0;
  endtask

  function automatic logic [31:0] rnd_word();
    int unsigned r;
    logic [3:0] op;
    r = $urandom % 16;
    if (r < 5)       op = 4'd0;
    else if (r < 7)  op = 4'd1;
    else if (r < 9)  op = 4'd2;
    else if (r < 11) op = 4'd3;
    else if (r < 12) op = 4'd4;
    else if (r < 13) op = 4'd5;
    else if (r < 14) op = 4'd6;
    else             op = 4'(7 + ($urandom % 9));
    return {op, 28'($urandom)};
  endfunction

  initial begin
    void'($urandom(32'd2024));
    clear_mem();
    model_reset();
    do_reset();

    // R7/R6: counted loop, body 12..14 runs three times, then END at 15
    clear_mem();
    mem[10] = mk(4'd4, 1'b0, 2'd0, 8'd12);
    mem[11] = mk(4'd5, 1'b0, 2'd0, 8'd2);
    mem[13] = mk(4'd3, 1'b0, 2'd0, 8'd0);
    mem[15] = mk(4'd6, 1'b0, 2'd0, 8'd0);
    do_reset();
    start = 1'b1; start_addr = 8'd10;
    tick();
    start = 1'b0;
    for (int i = 0; i < 30; i++) tick();
    check("R7 loop exit then R8 rest at end+1", 8'd16, 1'b0);

    // R9: END while DMA busy; R5: conditional jump on dma_busy set
    clear_mem();
    mem[40] = mk(4'd2, 1'b1, 2'd0, 8'd60);
    mem[41] = mk(4'd0, 1'b0, 2'd0, 8'd0);
    mem[60] = mk(4'd6, 1'b0, 2'd0, 8'd0);
    do_reset();
    dma_busy = 1'b1;
    start = 1'b1; start_addr = 8'd40;
    tick();
    start = 1'b0;
    for (int i = 0; i < 8; i++) tick();
    check("R9 halt with dma busy", 8'd61, 1'b0);

    // R5: same branch with dma idle falls through to 42.. then runs on; R2 ignored start
    do_reset();
    dma_busy = 1'b0;
    mem[43] = mk(4'd6, 1'b0, 2'd0, 8'd0);
    start = 1'b1; start_addr = 8'd40;
    tick();
    start_addr = 8'd200;
    tick();
    start = 1'b0;
    for (int i = 0; i < 8; i++) tick();
    check("R5 fall through, R2 start ignored", 8'd44, 1'b0);

    // random programs
    for (int p = 0; p < 160; p++) begin
      for (int i = 0; i < 256; i++) mem[i] = rnd_word();
      do_reset();
      start = 1'b1; start_addr = 8'($urandom);
      for (int c = 0; c < 240; c++) begin
        tick();
        start      = (($urandom % 6) == 0);
        start_addr = 8'($urandom);
        flags      = 3'($urandom);
        dma_busy   = 1'($urandom);
      end
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

endmodule